// File: doc/BRIEF.md
# Multi-bank static memory controller

This block sits between a 32-bit system bus and an external asynchronous static memory bus. It takes one word-sized read or write at a time and decodes the system address into one of eight banks and a 24-bit byte offset within that bank. It then runs the external cycle with a chip select, an output enable and a write enable, and returns a single-cycle response that carries read data or a bus error.

Each bank has its own static configuration: the chip-select polarity, the data width (8, 16 or 32 bits), the strobe length for reads and for writes, the number of idle bus cycles that separate accesses, and a write-protect flag. A word access to a narrow bank becomes several external beats. The beat address steps up by the bank width. Read bytes are assembled little-endian, and write bytes are sent lowest byte first on the low lanes.

A request is taken in a cycle where `req_i` and `ready_o` are both high. Only one access is in flight at a time.

Top module: `smc_bank_ctrl`

## Requirements
- R1: A request whose address bits [31:29] differ from 3'b010 starts no external cycle. The cycle after acceptance gives `rsp_valid_o`=1 and `rsp_err_o`=1.
- R2: Address bits [28:26] select the bank, and bank n drives chip select `mem_cs_o[n]`.
- R3: Address bits [23:0] appear on `mem_addr_o` for the first beat. Bits [25:24] have no effect, so nonzero values reach the same bank location.
- R4: If `cfg_cs_pol_i[n]`=1, chip select n is active high; if it is 0, chip select n is active low. Every bank not being accessed sits at its inactive level. Exactly one chip select is active whenever a strobe is low.
- R5: Each read beat holds `mem_oe_no` low for `cfg_rd_wait_i[5n+4:5n]`+1 cycles, 1 to 32. Each write beat holds `mem_we_no` low for `cfg_wr_wait_i[5n+4:5n]`+1 cycles. The two strobes are never low together.
- R6: `cfg_width_i[2n+1:2n]` sets the width of bank n: 0 gives 8 bits in 4 beats, 1 gives 16 bits in 2 beats, and 2 or 3 gives 32 bits in 1 beat. Beat k uses address offset+k*bytes and carries bytes starting at k*bytes on the low data lanes, little-endian.
- R7: Bus idle cycles are inserted before an access when the previous external access had the other direction or a different bank. There are `cfg_idle_i[4m+3:4m]`+1 of them (1 to 16), where m is the previous bank. None are inserted before the first access after reset or between same-direction accesses to the same bank.
- R8: A write to a bank with `cfg_wp_i[n]`=1 starts no external cycle, returns an error response the next cycle, and leaves the memory unchanged.
- R9: `ready_o` is high only while no access is in progress. `rsp_valid_o` pulses for one cycle right after the last strobe cycle, with `rsp_err_o`=0. For a read it carries the assembled word on `rsp_rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | System byte address |
| req_wdata_i | input | 32 | Write data |
| ready_o | output | 1 | Controller idle, request accepted when high |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_err_o | output | 1 | Error response (unmapped or protected) |
| rsp_rdata_o | output | 32 | Read data |
| cfg_cs_pol_i | input | 8 | Per-bank chip-select polarity, 1 = active high |
| cfg_width_i | input | 16 | Per-bank width code, 2 bits each |
| cfg_rd_wait_i | input | 40 | Per-bank read strobe length minus one, 5 bits each |
| cfg_wr_wait_i | input | 40 | Per-bank write strobe length minus one, 5 bits each |
| cfg_idle_i | input | 32 | Per-bank idle cycles minus one, 4 bits each |
| cfg_wp_i | input | 8 | Per-bank write protect |
| mem_cs_o | output | 8 | Chip selects |
| mem_addr_o | output | 24 | External byte address |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_wdata_o | output | 32 | External write data |
| mem_rdata_i | input | 32 | External read data |

## Verification
Some rules are checked by assertions on every cycle. A strobe always has exactly one chip select active at its configured level. The two strobes are never low together. No write strobe reaches a protected bank. Unmapped requests get an error on the next cycle. Each response is a single-cycle pulse followed by ready. Other behaviour only shows up in the bench's scenarios, where a per-cycle reference is compared against the pins: the exact count of idle cycles after a change of direction or bank, the beat-by-beat addresses and byte lanes for 8- and 16-bit banks, little-endian reassembly of read words, the address mirroring, and the fact that a blocked write leaves the memory contents unchanged.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int unsigned NUM_BANKS = 8;
  localparam int unsigned OFF_W     = 24;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned WAIT_W    = 5;
  localparam int unsigned IDLE_W    = 4;
  localparam logic [2:0]  BASE_SEL  = 3'b010;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TURN,
    ST_ACC,
    ST_RESP
  } smc_state_e;

  // width code: 0 = 8 bit, 1 = 16 bit, 2/3 = 32 bit
  function automatic logic [1:0] last_beat(input logic [1:0] code);
    case (code)
      2'd0:    return 2'd3;
      2'd1:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/smc_addr_dec.sv
module smc_addr_dec #(
  parameter int unsigned BANK_W = 3,
  parameter int unsigned OFF_W  = 24
) (
  input  logic [31:0]       addr_i,
  output logic              hit_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [OFF_W-1:0]  off_o
);
  import smc_pkg::*;

  logic unused_mirror;

  assign hit_o         = (addr_i[31:29] == BASE_SEL);
  assign bank_o        = addr_i[26 +: BANK_W];
  assign off_o         = addr_i[OFF_W-1:0];
  assign unused_mirror = ^addr_i[25:24];
endmodule

// File: rtl/smc_cnt.sv
module smc_cnt #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R5
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |-> !zero_o);
endmodule

// File: rtl/smc_lane.sv
module smc_lane #(
  parameter int unsigned DW = 32,
  parameter int unsigned BW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    code_i,
  input  logic [BW-1:0] beat_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          clr_i,
  input  logic          cap_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] wlane_o,
  output logic [DW-1:0] rword_o
);
  localparam int unsigned SH_W = $clog2(DW);

  logic [SH_W-1:0] sh;
  logic [DW-1:0]   mask;
  logic [DW-1:0]   rword_q;

  always_comb begin
    case (code_i)
      2'd0: begin
        sh   = SH_W'({beat_i, 3'b000});
        mask = DW'(8'hff);
      end
      2'd1: begin
        sh   = SH_W'({beat_i, 4'b0000});
        mask = DW'(16'hffff);
      end
      default: begin
        sh   = '0;
        mask = '1;
      end
    endcase
  end

  assign wlane_o = wdata_i >> sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rword_q <= '0;
    else if (clr_i)  rword_q <= '0;
    else if (cap_i)  rword_q <= rword_q | ((rdata_i & mask) << sh);
  end

  assign rword_o = rword_q;
endmodule

// File: rtl/smc_bank_ctrl.sv
module smc_bank_ctrl
  import smc_pkg::*;
#(
  parameter int unsigned NB  = NUM_BANKS,
  parameter int unsigned AW  = OFF_W,
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned WW  = WAIT_W,
  parameter int unsigned IW  = IDLE_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           req_we_i,
  input  logic [31:0]    req_addr_i,
  input  logic [DW-1:0]  req_wdata_i,
  output logic           ready_o,
  output logic           rsp_valid_o,
  output logic           rsp_err_o,
  output logic [DW-1:0]  rsp_rdata_o,
  input  logic [NB-1:0]  cfg_cs_pol_i,
  input  logic [2*NB-1:0] cfg_width_i,
  input  logic [WW*NB-1:0] cfg_rd_wait_i,
  input  logic [WW*NB-1:0] cfg_wr_wait_i,
  input  logic [IW*NB-1:0] cfg_idle_i,
  input  logic [NB-1:0]  cfg_wp_i,
  output logic [NB-1:0]  mem_cs_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic           mem_oe_no,
  output logic           mem_we_no,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i
);
  localparam int unsigned BANK_W = $clog2(NB);
  localparam int unsigned CNT_W  = (WW > IW) ? WW : IW;

  smc_state_e state_q;

  logic [BANK_W-1:0] bank_q, last_bank_q, d_bank;
  logic [AW-1:0]     off_q, d_off, beat_off;
  logic [DW-1:0]     wdata_q;
  logic [1:0]        beat_q, w_code;
  logic              we_q, err_q, last_vld_q, last_we_q;
  logic              d_hit, acc, rej, turn, cnt_zero, cnt_load, cnt_dec, beat_end;
  logic [CNT_W-1:0]  cnt_val;

  logic [WW-1:0] rd_w [NB];
  logic [WW-1:0] wr_w [NB];
  logic [IW-1:0] idl_w [NB];
  logic [1:0]    wid_w [NB];
  logic [NB-1:0] act;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    assign rd_w[g]     = cfg_rd_wait_i[g*WW +: WW];
    assign wr_w[g]     = cfg_wr_wait_i[g*WW +: WW];
    assign idl_w[g]    = cfg_idle_i[g*IW +: IW];
    assign wid_w[g]    = cfg_width_i[g*2 +: 2];
    assign act[g]      = (state_q == ST_ACC) && (bank_q == BANK_W'(g));
    assign mem_cs_o[g] = act[g] ? cfg_cs_pol_i[g] : ~cfg_cs_pol_i[g];
  end

  smc_addr_dec #(.BANK_W(BANK_W), .OFF_W(AW)) u_dec (
    .addr_i (req_addr_i),
    .hit_o  (d_hit),
    .bank_o (d_bank),
    .off_o  (d_off)
  );

  assign ready_o  = (state_q == ST_IDLE);
  assign acc      = req_i && ready_o;
  assign rej      = !d_hit || (req_we_i && cfg_wp_i[d_bank]);
  assign turn     = last_vld_q && ((last_we_q != req_we_i) || (last_bank_q != d_bank));
  assign w_code   = wid_w[bank_q];
  assign beat_end = (state_q == ST_ACC) && cnt_zero;

  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = '0;
    if (acc && !rej) begin
      cnt_load = 1'b1;
      if (turn)          cnt_val = CNT_W'(idl_w[last_bank_q]);
      else if (req_we_i) cnt_val = CNT_W'(wr_w[d_bank]);
      else               cnt_val = CNT_W'(rd_w[d_bank]);
    end else if ((state_q == ST_TURN && cnt_zero) ||
                 (beat_end && beat_q != last_beat(w_code))) begin
      cnt_load = 1'b1;
      cnt_val  = we_q ? CNT_W'(wr_w[bank_q]) : CNT_W'(rd_w[bank_q]);
    end
  end

  assign cnt_dec = (state_q == ST_TURN || state_q == ST_ACC) && !cnt_zero;

  smc_cnt #(.W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .dec_i      (cnt_dec),
    .zero_o     (cnt_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      bank_q      <= '0;
      off_q       <= '0;
      we_q        <= 1'b0;
      wdata_q     <= '0;
      beat_q      <= '0;
      err_q       <= 1'b0;
      last_vld_q  <= 1'b0;
      last_we_q   <= 1'b0;
      last_bank_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (acc) begin
          bank_q  <= d_bank;
          off_q   <= d_off;
          we_q    <= req_we_i;
          wdata_q <= req_wdata_i;
          beat_q  <= '0;
          err_q   <= rej;
          if (rej) begin
            state_q <= ST_RESP;
          end else begin
            last_vld_q  <= 1'b1;
            last_we_q   <= req_we_i;
            last_bank_q <= d_bank;
            state_q     <= turn ? ST_TURN : ST_ACC;
          end
        end
        ST_TURN: if (cnt_zero) state_q <= ST_ACC;
        ST_ACC: if (cnt_zero) begin
          if (beat_q == last_beat(w_code)) state_q <= ST_RESP;
          else                             beat_q  <= beat_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (w_code)
      2'd0:    beat_off = AW'(beat_q);
      2'd1:    beat_off = AW'({beat_q, 1'b0});
      default: beat_off = '0;
    endcase
  end

  assign mem_addr_o  = off_q + beat_off;
  assign mem_oe_no   = !((state_q == ST_ACC) && !we_q);
  assign mem_we_no   = !((state_q == ST_ACC) && we_q);
  assign rsp_valid_o = (state_q == ST_RESP);
  assign rsp_err_o   = rsp_valid_o && err_q;

  smc_lane #(.DW(DW), .BW(2)) u_lane (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .code_i  (w_code),
    .beat_i  (beat_q),
    .wdata_i (wdata_q),
    .clr_i   (acc),
    .cap_i   (beat_end && !we_q),
    .rdata_i (mem_rdata_i),
    .wlane_o (mem_wdata_o),
    .rword_o (rsp_rdata_o)
  );

  // R1
  unmapped_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && req_addr_i[31:29] != BASE_SEL) |=> (rsp_valid_o && rsp_err_o));
  // R4
  strobe_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_oe_no || !mem_we_no) |-> ($countones(~(mem_cs_o ^ cfg_cs_pol_i)) == 1));
  // R5
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no));
  // R8
  wp_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> !cfg_wp_i[bank_q]);
  // R9
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && ready_o));
endmodule

// File: tb/smc_bank_ctrl_tb.sv
module smc_bank_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req, req_we;
  logic [31:0] req_addr, req_wdata;
  logic        ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [7:0]  pol, wp;
  logic [15:0] width_v;
  logic [39:0] rdw_v, wrw_v;
  logic [31:0] idle_v;
  logic [7:0]  cs;
  logic [23:0] maddr;
  logic        oe_n, we_n;
  logic [31:0] mwdata, mrdata;

  int wcode [8] = '{2, 1, 0, 2, 2, 2, 2, 0};
  int rdw   [8] = '{0, 2, 1, 0, 0, 31, 0, 0};
  int wrw   [8] = '{0, 1, 3, 0, 0, 0, 0, 0};
  int idl   [8] = '{0, 3, 1, 2, 0, 0, 0, 15};

  smc_bank_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_i(req), .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .ready_o(ready), .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .cfg_cs_pol_i(pol), .cfg_width_i(width_v), .cfg_rd_wait_i(rdw_v), .cfg_wr_wait_i(wrw_v),
    .cfg_idle_i(idle_v), .cfg_wp_i(wp),
    .mem_cs_o(cs), .mem_addr_o(maddr), .mem_oe_no(oe_n), .mem_we_no(we_n),
    .mem_wdata_o(mwdata), .mem_rdata_i(mrdata)
  );

  function automatic int nb_of(int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : 4;
  endfunction

  // behavioural external SRAM, shared bus, byte array per bank
  logic [7:0] sram [0:2047];
  logic [7:0] gold [0:2047];
  int  sel;
  bit  any;
  always_comb begin
    any = 1'b0;
    sel = 0;
    for (int n = 0; n < 8; n++) if (cs[n] == pol[n]) begin any = 1'b1; sel = n; end
    mrdata = '0;
    if (any && !oe_n)
      for (int k = 0; k < 4; k++) mrdata[8*k +: 8] = sram[{sel[2:0], 8'(int'(maddr[7:0]) + k)}];
  end
  always @(posedge clk)
    if (any && !we_n)
      for (int k = 0; k < nb_of(wcode[sel]); k++)
        sram[{sel[2:0], 8'(int'(maddr[7:0]) + k)}] <= mwdata[8*k +: 8];

  typedef struct {
    bit          rdy;
    bit          rv;
    bit          rerr;
    bit          act;
    int          bank;
    logic [23:0] addr;
    bit          we;
    logic [31:0] wd;
    logic [31:0] wm;
    bit          chkrd;
    logic [31:0] rd;
    string       tag;
  } exp_t;
  exp_t q[$];

  int checks = 0;
  int errors = 0;
  bit last_vld = 0, last_we = 0;
  int last_bank = 0;

  task automatic chk(bit ok, string req_tag, string scen, string what, logic [31:0] a, logic [31:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) %s act=%h exp=%h", req_tag, scen, what, a, e);
    end
  endtask

  function automatic exp_t blank(bit rdy, string tag);
    exp_t e;
    e.rdy = rdy; e.rv = 0; e.rerr = 0; e.act = 0; e.bank = 0; e.addr = '0;
    e.we = 0; e.wd = '0; e.wm = '0; e.chkrd = 0; e.rd = '0; e.tag = tag;
    return e;
  endfunction

  // per-cycle comparison against the queued reference
  bit run = 0;
  always @(negedge clk) if (run) begin
    exp_t e;
    logic [7:0] ecs;
    if (q.size() > 0) e = q.pop_front();
    else              e = blank(1, "idle");
    for (int n = 0; n < 8; n++) ecs[n] = (e.act && e.bank == n) ? pol[n] : ~pol[n];
    chk(ready == e.rdy, "R9", e.tag, "ready", 32'(ready), 32'(e.rdy));
    chk(rsp_valid == e.rv, "R9", e.tag, "rsp_valid", 32'(rsp_valid), 32'(e.rv));
    if (e.rv) chk(rsp_err == e.rerr, "R9", e.tag, "rsp_err", 32'(rsp_err), 32'(e.rerr));
    if (e.rv && e.chkrd) chk(rsp_rdata == e.rd, "R6", e.tag, "rdata", rsp_rdata, e.rd);
    chk(cs == ecs, "R4", e.tag, "cs", 32'(cs), 32'(ecs));
    chk(oe_n == !(e.act && !e.we), "R5", e.tag, "oe_n", 32'(oe_n), 32'(!(e.act && !e.we)));
    chk(we_n == !(e.act && e.we), "R5", e.tag, "we_n", 32'(we_n), 32'(!(e.act && e.we)));
    if (e.act) chk(maddr == e.addr, "R3", e.tag, "addr", 32'(maddr), 32'(e.addr));
    if (e.act && e.we) chk((mwdata & e.wm) == (e.wd & e.wm), "R6", e.tag, "wdata", mwdata & e.wm, e.wd & e.wm);
  end

  function automatic logic [31:0] mk(int b, int mir, int off);
    return {3'b010, 3'(b), 2'(mir), 24'(off)};
  endfunction

  task automatic do_req(bit we, logic [31:0] addr, logic [31:0] wd, string tag);
    bit hit;
    int b, off, nb, w;
    exp_t e;
    hit = (addr[31:29] == 3'b010);
    b   = int'(addr[28:26]);
    off = int'(addr[23:0]);
    @(posedge clk); #1;
    req = 1; req_we = we; req_addr = addr; req_wdata = wd;
    q.push_back(blank(1, tag));
    if (!hit || (we && wp[b])) begin
      e = blank(0, tag); e.rv = 1; e.rerr = 1; q.push_back(e);
    end else begin
      if (last_vld && (last_we != we || last_bank != b))
        for (int c = 0; c <= idl[last_bank]; c++) q.push_back(blank(0, tag));
      nb = nb_of(wcode[b]);
      w  = we ? wrw[b] : rdw[b];
      for (int k = 0; k < 4 / nb; k++)
        for (int c = 0; c <= w; c++) begin
          e = blank(0, tag);
          e.act = 1; e.bank = b; e.we = we;
          e.addr = 24'(off + k * nb);
          e.wd = wd >> (8 * k * nb);
          e.wm = (nb == 4) ? 32'hffffffff : (nb == 2) ? 32'h0000ffff : 32'h000000ff;
          q.push_back(e);
        end
      e = blank(0, tag); e.rv = 1;
      if (!we) begin
        e.chkrd = 1;
        for (int k = 0; k < 4; k++) e.rd[8*k +: 8] = gold[{3'(b), 8'(off + k)}];
      end else begin
        for (int k = 0; k < 4; k++) gold[{3'(b), 8'(off + k)}] = wd[8*k +: 8];
      end
      q.push_back(e);
      last_vld = 1; last_we = we; last_bank = b;
    end
    @(posedge clk); #1;
    req = 0;
    while (q.size() != 0) begin @(posedge clk); #1; end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R9", "watchdog", "timeout", 32'd0, 32'd1);
    summary();
    $finish;
  end

  initial begin
    req = 0; req_we = 0; req_addr = '0; req_wdata = '0;
    pol = 8'b1000_0010;
    wp  = 8'b0000_1000;
    for (int n = 0; n < 8; n++) begin
      width_v[2*n +: 2] = 2'(wcode[n]);
      rdw_v[5*n +: 5]   = 5'(rdw[n]);
      wrw_v[5*n +: 5]   = 5'(wrw[n]);
      idle_v[4*n +: 4]  = 4'(idl[n]);
    end
    for (int i = 0; i < 2048; i++) begin
      sram[i] = 8'(i * 37 + 11);
      gold[i] = 8'(i * 37 + 11);
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // reset state
    chk(ready == 1, "R9", "reset", "ready", 32'(ready), 32'd1);
    chk(cs == ~pol, "R4", "reset", "cs", 32'(cs), 32'(~pol));
    chk(oe_n && we_n, "R5", "reset", "strobes", 32'({oe_n, we_n}), 32'd3);
    run = 1;

    do_req(1, mk(0, 0, 'h10), 32'haabbccdd, "R2 b0 write");
    do_req(1, mk(0, 0, 'h14), 32'h11223344, "R7 same dir/bank");
    do_req(0, mk(0, 0, 'h10), 32'h0, "R7 dir change");
    do_req(0, mk(0, 0, 'h14), 32'h0, "R9 b0 read");
    do_req(1, mk(1, 0, 'h20), 32'hcafef00d, "R6 16b write");
    do_req(0, mk(1, 0, 'h20), 32'h0, "R6 16b read");
    do_req(1, mk(2, 0, 'h30), 32'h5a6b7c8d, "R6 8b write");
    do_req(0, mk(2, 0, 'h30), 32'h0, "R6 8b read");
    do_req(0, mk(2, 3, 'h30), 32'h0, "R3 mirror");
    do_req(1, mk(3, 0, 'h40), 32'hdeadbeef, "R8 protected write");
    do_req(0, mk(3, 0, 'h40), 32'h0, "R8 unchanged");
    do_req(0, 32'h2000_0010, 32'h0, "R1 unmapped read");
    do_req(1, 32'h8400_0000, 32'h12345678, "R1 unmapped write");
    do_req(0, mk(5, 0, 'h50), 32'h0, "R5 32 cycle strobe");
    do_req(1, mk(7, 0, 'h60), 32'h0badcafe, "R7 b7 write");
    do_req(0, mk(7, 0, 'h60), 32'h0, "R7 16 idle");
    do_req(0, mk(4, 1, 'h70), 32'h0, "R2 b4 read");

    repeat (3) @(posedge clk);
    run = 0;
    summary();
    $finish;
  end
endmodule